// File: doc/BRIEF.md
# Word Redundancy Repair Array

This block holds a small set of spare memory words beside a main memory and uses them to replace faulty words. A self-test engine runs it in repair mode. Each time the engine reports a failing location with a fault pulse, the block loads the failing address and the data that location should hold into a spare word. An address that already owns a spare only has its data refreshed. When a new failing address arrives and no spare is left, a sticky overflow flag goes high.

In normal mode every access address is compared at once against all programmed spares. On a write that hits, the data lands in the spare and the main-memory write enable is held low. On a read that hits, the output multiplexer returns the spare data in place of the memory's read data. Accesses that miss pass straight through. Spare count and word widths are parameters. The main memory's read data is expected in the same cycle as the address.

Top module: `word_repair_array`

## Requirements
- R1: After reset no spare is programmed and `overflow_o` is low. Every read returns `mem_rd_data_i` with `hit_o` low, and every write asserts `mem_wr_en_o`.
- R2: With `test_mode_i`=1, a cycle with `fault_i`=1 on an address that owns no spare programs a free spare with `fault_addr_i` and `fault_data_i`. From the next cycle, a normal-mode read of that address returns the stored data.
- R3: Up to `N_SPARES` distinct faulty addresses are each repaired independently without raising `overflow_o`.
- R4: A fault on an address that already owns a spare replaces that spare's data and consumes no further spare.
- R5: A fault on a new address while all spares are programmed sets `overflow_o` from the next cycle. The flag stays high until reset, and no existing spare changes.
- R6: In normal mode, a write (`wr_en_i`=1) to a repaired address keeps `mem_wr_en_o` low in that cycle and stores `wr_data_i` in the spare from the next cycle.
- R7: In normal mode, a write to an address without a spare asserts `mem_wr_en_o` in the same cycle.
- R8: In normal mode, a read (`rd_en_i`=1) to a repaired address drives the spare data on `rd_data_o` with `hit_o`=1 in the same cycle. A read of any other address drives `mem_rd_data_i` with `hit_o`=0.
- R9: `fault_i` has no effect while `test_mode_i`=0.
- R10: While `test_mode_i`=1, accesses bypass the spares: `hit_o` is 0, `rd_data_o` equals `mem_rd_data_i`, `mem_wr_en_o` follows `wr_en_i`, and spare data is left unchanged.
- R11: Once the spares are full, a fault on an address that already owns a spare still updates its data and does not count as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | 1 = repair mode, 0 = normal mode |
| fault_i | input | 1 | Fault pulse from the self-test engine |
| fault_addr_i | input | ADDR_W | Failing address |
| fault_data_i | input | DATA_W | Correct data for the failing address |
| acc_addr_i | input | ADDR_W | Access address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| mem_rd_data_i | input | DATA_W | Read data from the main memory |
| mem_wr_en_o | output | 1 | Write enable to the main memory |
| rd_data_o | output | DATA_W | Read data after the repair multiplexer |
| hit_o | output | 1 | Access address is served by a spare |
| overflow_o | output | 1 | A new fault found no free spare |

## Verification
A spare whose flag, address or data is wrong shows up on the next normal-mode read of the affected address. `rd_data_o` returns memory data where spare data was expected, or the reverse, within one cycle of the access. A miscounting allocation pointer shows up later: `overflow_o` rises one fault too early or too late, or a later distinct fault silently fails to repair. The bench therefore fills the spares exactly, repeats addresses, and then reads back every repaired location.

// File: rtl/wra_pkg.sv
package wra_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_REPAIR = 1'b1
  } wra_mode_e;

  localparam int unsigned DEF_ADDR_W   = 8;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_N_SPARES = 4;
endpackage

// File: rtl/wra_spare_slot.sv
module wra_spare_slot #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              claim_i,
  input  logic              refresh_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (claim_i) begin
      vld_o  <= 1'b1;
      addr_o <= addr_i;
      data_o <= data_i;
    end else if (refresh_i) begin
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/wra_match.sv
module wra_match #(
  parameter int unsigned N_SPARES = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8
) (
  input  logic [N_SPARES-1:0]             vld_i,
  input  logic [N_SPARES-1:0][ADDR_W-1:0] addr_i,
  input  logic [N_SPARES-1:0][DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0]               key_i,
  output logic [N_SPARES-1:0]             hit_vec_o,
  output logic                            hit_o,
  output logic [DATA_W-1:0]               data_o
);
  for (genvar i = 0; i < N_SPARES; i++) begin : g_cmp
    assign hit_vec_o[i] = vld_i[i] && (addr_i[i] == key_i);
  end

  assign hit_o = |hit_vec_o;

  // at most one spare per address, so an AND-OR mux suffices
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_SPARES; i++) begin
      data_o = data_o | (data_i[i] & {DATA_W{hit_vec_o[i]}});
    end
  end
endmodule

// File: rtl/wra_alloc.sv
module wra_alloc #(
  parameter int unsigned N_SPARES = 4,
  localparam int unsigned CNT_W   = $clog2(N_SPARES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic [CNT_W-1:0] ptr_o,
  output logic             full_o,
  output logic             overflow_o
);
  assign full_o = (ptr_o == CNT_W'(N_SPARES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o      <= '0;
      overflow_o <= 1'b0;
    end else if (req_i) begin
      if (full_o) overflow_o <= 1'b1;
      else        ptr_o      <= ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/word_repair_array.sv
module word_repair_array
  import wra_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned N_SPARES = DEF_N_SPARES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_mode_i,
  input  logic              fault_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic [DATA_W-1:0] fault_data_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              mem_wr_en_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              hit_o,
  output logic              overflow_o
);
  localparam int unsigned CNT_W = $clog2(N_SPARES + 1);

  wra_mode_e mode;
  assign mode = wra_mode_e'(test_mode_i);

  logic [N_SPARES-1:0]             spare_vld;
  logic [N_SPARES-1:0][ADDR_W-1:0] spare_addr;
  logic [N_SPARES-1:0][DATA_W-1:0] spare_data;
  logic [N_SPARES-1:0]             hit_vec;
  logic [N_SPARES-1:0]             claim_vec;
  logic [N_SPARES-1:0]             refresh_vec;
  logic [ADDR_W-1:0]               key;
  logic [DATA_W-1:0]               load_data;
  logic [DATA_W-1:0]               match_data;
  logic [CNT_W-1:0]                alloc_ptr;
  logic                            any_hit;
  logic                            alloc_full;
  logic                            fault_go;
  logic                            new_fault;
  logic                            norm_hit;

  // repair mode looks up the fault address, normal mode the access address
  assign key       = (mode == MODE_REPAIR) ? fault_addr_i : acc_addr_i;
  assign load_data = (mode == MODE_REPAIR) ? fault_data_i : wr_data_i;
  assign fault_go  = (mode == MODE_REPAIR) && fault_i;
  assign new_fault = fault_go && !any_hit;
  assign norm_hit  = (mode == MODE_NORMAL) && any_hit;

  wra_match #(
    .N_SPARES(N_SPARES),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_match (
    .vld_i    (spare_vld),
    .addr_i   (spare_addr),
    .data_i   (spare_data),
    .key_i    (key),
    .hit_vec_o(hit_vec),
    .hit_o    (any_hit),
    .data_o   (match_data)
  );

  wra_alloc #(
    .N_SPARES(N_SPARES)
  ) u_alloc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (new_fault),
    .ptr_o     (alloc_ptr),
    .full_o    (alloc_full),
    .overflow_o(overflow_o)
  );

  for (genvar i = 0; i < N_SPARES; i++) begin : g_spare
    assign claim_vec[i]   = new_fault && !alloc_full && (alloc_ptr == CNT_W'(i));
    assign refresh_vec[i] = hit_vec[i] && (fault_go || ((mode == MODE_NORMAL) && wr_en_i));

    wra_spare_slot #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .claim_i  (claim_vec[i]),
      .refresh_i(refresh_vec[i]),
      .addr_i   (fault_addr_i),
      .data_i   (load_data),
      .vld_o    (spare_vld[i]),
      .addr_o   (spare_addr[i]),
      .data_o   (spare_data[i])
    );
  end

  assign hit_o       = norm_hit && (rd_en_i || wr_en_i);
  assign rd_data_o   = (norm_hit && rd_en_i) ? match_data : mem_rd_data_i;
  assign mem_wr_en_o = wr_en_i && !norm_hit;
endmodule

// File: rtl/wra_checker.sv
module wra_checker #(
  parameter int unsigned N_SPARES = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                test_mode_i,
  input logic                fault_i,
  input logic                wr_en_i,
  input logic                hit_o,
  input logic                mem_wr_en_o,
  input logic                overflow_o,
  input logic [N_SPARES-1:0] spare_vld,
  input logic [N_SPARES-1:0] hit_vec
);
  // R5
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  // R5
  overflow_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(fault_i && test_mode_i));

  // R10
  test_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i |-> !hit_o);

  // R6
  hit_write_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_o) |-> !mem_wr_en_o);

  // R4
  single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  // R3
  spare_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((spare_vld & $past(spare_vld)) == $past(spare_vld)));

  // R9
  normal_no_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_i |=> $stable(spare_vld));
endmodule

bind word_repair_array wra_checker #(
  .N_SPARES(N_SPARES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .test_mode_i(test_mode_i),
  .fault_i    (fault_i),
  .wr_en_i    (wr_en_i),
  .hit_o      (hit_o),
  .mem_wr_en_o(mem_wr_en_o),
  .overflow_o (overflow_o),
  .spare_vld  (spare_vld),
  .hit_vec    (hit_vec)
);

// File: tb/sim_word_repair_array.sv
module sim_word_repair_array;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          test_mode = 1'b0;
  logic          fault = 1'b0;
  logic [AW-1:0] fault_addr = '0;
  logic [DW-1:0] fault_data = '0;
  logic [AW-1:0] acc_addr = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] mem_rd = '0;
  logic          mem_wr_en;
  logic [DW-1:0] rd_data;
  logic          hit;
  logic          overflow;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  word_repair_array #(.ADDR_W(AW), .DATA_W(DW), .N_SPARES(NS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .test_mode_i(test_mode), .fault_i(fault),
    .fault_addr_i(fault_addr), .fault_data_i(fault_data), .acc_addr_i(acc_addr),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .wr_data_i(wr_data), .mem_rd_data_i(mem_rd),
    .mem_wr_en_o(mem_wr_en), .rd_data_o(rd_data), .hit_o(hit), .overflow_o(overflow)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    test_mode = 1'b1; fault = 1'b1; fault_addr = a; fault_data = d;
    @(negedge clk);
    fault = 1'b0; test_mode = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] m,
                        input logic [DW-1:0] exp, input logic exp_hit);
    @(negedge clk);
    acc_addr = a; mem_rd = m; rd_en = 1'b1;
    #1;
    chk(req, "rd_data", int'(rd_data), int'(exp));
    chk(req, "hit", int'(hit), int'(exp_hit));
    rd_en = 1'b0;
  endtask

  task automatic wr_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic exp_mem_wr);
    @(negedge clk);
    acc_addr = a; wr_data = d; wr_en = 1'b1;
    #1;
    chk(req, "mem_wr_en", int'(mem_wr_en), int'(exp_mem_wr));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1", 8'h05, 8'h3C, 8'h3C, 1'b0);
    chk("R1", "overflow", int'(overflow), 0);
    wr_chk("R1", 8'h05, 8'h01, 1'b1);
  endtask

  task automatic t_program();
    inject(8'h10, 8'hA5);
    rd_chk("R2", 8'h10, 8'h00, 8'hA5, 1'b1);
    rd_chk("R8", 8'h11, 8'h77, 8'h77, 1'b0);
  endtask

  task automatic t_update();
    inject(8'h10, 8'h5A);
    rd_chk("R4", 8'h10, 8'h00, 8'h5A, 1'b1);
  endtask

  task automatic t_fill();
    inject(8'h20, 8'h33);
    inject(8'h30, 8'h44);
    inject(8'h40, 8'h55);
    chk("R4", "overflow after refill", int'(overflow), 0);
    rd_chk("R3", 8'h20, 8'h00, 8'h33, 1'b1);
    rd_chk("R3", 8'h30, 8'h00, 8'h44, 1'b1);
    rd_chk("R3", 8'h40, 8'h00, 8'h55, 1'b1);
    rd_chk("R3", 8'h10, 8'h00, 8'h5A, 1'b1);
  endtask

  task automatic t_overflow();
    inject(8'h50, 8'h11);
    chk("R5", "overflow", int'(overflow), 1);
    rd_chk("R5", 8'h50, 8'h99, 8'h99, 1'b0);
    rd_chk("R5", 8'h20, 8'h00, 8'h33, 1'b1);
  endtask

  task automatic t_full_existing();
    inject(8'h30, 8'hEE);
    rd_chk("R11", 8'h30, 8'h00, 8'hEE, 1'b1);
  endtask

  task automatic t_normal_write();
    wr_chk("R6", 8'h20, 8'h42, 1'b0);
    rd_chk("R6", 8'h20, 8'h00, 8'h42, 1'b1);
    wr_chk("R7", 8'h60, 8'h42, 1'b1);
  endtask

  task automatic t_ignore_fault();
    @(negedge clk);
    test_mode = 1'b0; fault = 1'b1; fault_addr = 8'h40; fault_data = 8'h00;
    @(negedge clk);
    fault = 1'b0; fault_addr = 8'h70; fault_data = 8'h01;
    @(negedge clk);
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    rd_chk("R9", 8'h40, 8'hFF, 8'h55, 1'b1);
    rd_chk("R9", 8'h70, 8'h66, 8'h66, 1'b0);
  endtask

  task automatic t_test_mode();
    @(negedge clk);
    test_mode = 1'b1; acc_addr = 8'h20; mem_rd = 8'h13; rd_en = 1'b1;
    #1;
    chk("R10", "rd_data", int'(rd_data), 8'h13);
    chk("R10", "hit", int'(hit), 0);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b1; wr_data = 8'hFF;
    #1;
    chk("R10", "mem_wr_en", int'(mem_wr_en), 1);
    @(negedge clk);
    wr_en = 1'b0; test_mode = 1'b0;
    rd_chk("R10", 8'h20, 8'h00, 8'h42, 1'b1);
    chk("R5", "overflow still set", int'(overflow), 1);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "overflow after reset", int'(overflow), 0);
    rd_chk("R1", 8'h20, 8'h21, 8'h21, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_update();
    t_fill();
    t_overflow();
    t_full_existing();
    t_normal_write();
    t_ignore_fault();
    t_test_mode();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule